// File: doc/BRIEF.md
# Serial-bus slave for a single DAC code

This block is a two-wire serial-bus slave that owns one 7-bit DAC code register. A bus master addresses it with a fixed 7-bit device address and then sends a single command byte. The upper seven bits of that byte hold a code. The lowest bit selects where the code goes: it can be written to the live DAC register, or it can be offered to a nonvolatile store controller. A read returns the live code. The block samples the bus lines with its own system clock. It filters out short glitches and finds START and STOP conditions. It pulls SDA low through an open-drain output enable.

Store commands go through a simple handshake. The store controller holds `store_ready_i` high while it can take a new code; it drops it while it is busy programming or once its bank is full. When the last bit of the command byte has been sampled, the slave acknowledges a store only if `store_ready_i` is high. After that acknowledge it sends a one-cycle `store_req_o` pulse with the code.

Top module: `vcom_i2c_slave`

## Requirements
- R1: The device answers only to address bits 1001111 (write byte 0x9E, read byte 0x9F) with an ACK. Any other address byte gets no ACK. The slave then leaves SDA released and ignores the bus until the next START.
- R2: A write whose data byte has bit 0 = 1 is acknowledged. Data bits 7..1 are copied into the DAC register only at the end of that ACK pulse.
- R3: A write whose data byte has bit 0 = 0 is acknowledged when `store_ready_i` is high. After the ACK, `store_req_o` pulses for exactly one clock, `store_code_o` carries bits 7..1, and the DAC register is unchanged.
- R4: A store write that arrives while `store_ready_i` is low is answered with a NACK. No `store_req_o` pulse follows and the DAC register is unchanged.
- R5: A read is acknowledged, and the slave then sends the DAC register MSB first in bits 7..1, followed by a 0 in bit 0.
- R6: After reset the DAC register holds RESET_CODE (default 64), SDA is released and `store_req_o` is low.
- R7: A STOP before the data byte is complete aborts the transfer, and the DAC register keeps its value.
- R8: A STOP that falls within the same SCL high phase as the START before it is ignored, and the transfer continues.
- R9: Pulses on SCL or SDA that last fewer than FILT_CYC clocks have no effect on the received data.
- R10: A repeated START at any point restarts address reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data level seen on the bus |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain) |
| store_ready_i | input | 1 | Store controller can accept a code |
| store_req_o | output | 1 | One-cycle request to store a code |
| store_code_o | output | 7 | Code to be stored |
| dac_code_o | output | 7 | Live DAC register |

## Verification
The bench uses the default parameters: address 1001111, a 7-bit code, reset code 64 and a 5-clock glitch filter. It runs SCL with a 24-clock half period. That half period is long enough for the 8-clock delay through synchroniser, filter and edge detection, so the slave's responses fall in the correct bit slots. The 5-clock filter lets the bench inject 3-clock spikes on both lines that must be rejected. The reset code of 64 makes the first read distinguishable from an all-zero register.

// File: rtl/vcom_i2c_pkg.sv
// Shared types for the DAC-code serial slave.
package vcom_i2c_pkg;
    // Protocol phase of the slave
    typedef enum logic [2:0] {
        ST_IDLE,   // no transfer addressed to us
        ST_ADDR,   // shifting in the address byte
        ST_AACK,   // driving the address ACK
        ST_WDAT,   // shifting in the command byte
        ST_WACK,   // driving ACK/NACK for the command byte
        ST_RDAT,   // shifting out the DAC code
        ST_RACK,   // master's acknowledge slot after a read
        ST_IGN     // released, waiting for START or STOP
    } slv_state_t;
endpackage

// File: rtl/i2c_line_filter.sv
// Synchronises one bus line into the clk domain and rejects pulses
// shorter than FILT_CYC clocks.
// Assumes: FILT_CYC >= 2. The line idles high.
module i2c_line_filter #(
    parameter int FILT_CYC = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic clean_o
);
    localparam int CW = $clog2(FILT_CYC + 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] run_q;

    // Two-flop synchroniser
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], raw_i};
    end

    // Accept a new level only after FILT_CYC consecutive differing samples
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clean_o <= 1'b1;
            run_q   <= '0;
        end else if (sync_q[1] == clean_o) begin
            run_q <= '0;
        end else if (run_q == CW'(FILT_CYC - 1)) begin
            clean_o <= sync_q[1];
            run_q   <= '0;
        end else begin
            run_q <= run_q + 1'b1;
        end
    end

    // R9
    filt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clean_o != $past(clean_o)) |-> ($past(sync_q[1], 2) == clean_o));
endmodule

// File: rtl/i2c_bus_events.sv
// Detects SCL edges, START and STOP from the filtered lines. A STOP in
// the same SCL high phase as a START is masked.
// Assumes: both inputs are already synchronous to clk.
module i2c_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic start_o,
    output logic stop_o,
    output logic rise_o,
    output logic fall_o
);
    logic scl_q, sda_q, in_start_q;
    logic stop_raw;

    // Previous levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    assign rise_o   = scl_i & ~scl_q;
    assign fall_o   = ~scl_i & scl_q;
    assign start_o  = scl_i & scl_q & sda_q & ~sda_i;
    assign stop_raw = scl_i & scl_q & ~sda_q & sda_i;
    assign stop_o   = stop_raw & ~in_start_q;

    // Marks the SCL high phase that carried a START
    always_ff @(posedge clk) begin
        if (!rst_n)       in_start_q <= 1'b0;
        else if (start_o) in_start_q <= 1'b1;
        else if (fall_o)  in_start_q <= 1'b0;
    end

    // R8
    start_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> (!stop_o || !scl_q));
endmodule

// File: rtl/vcom_i2c_slave.sv
// Two-wire serial slave that controls a single DAC code. It takes an
// address byte and one command byte. Command bit 0 selects whether the
// code goes to the live register (1) or to the store controller (0).
// Assumes: no clock stretching, one command byte per transfer, and an SCL
// half period longer than FILT_CYC + 4 clocks.
module vcom_i2c_slave
    import vcom_i2c_pkg::*;
#(
    parameter int                ADDR_W     = 7,
    parameter logic [ADDR_W-1:0] DEV_ADDR   = 7'h4F,
    parameter int                CODE_W     = 7,
    parameter logic [CODE_W-1:0] RESET_CODE = 7'd64,
    parameter int                FILT_CYC   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    input  logic              store_ready_i,
    output logic              store_req_o,
    output logic [CODE_W-1:0] store_code_o,
    output logic [CODE_W-1:0] dac_code_o
);
    localparam int ADDR_BITS = ADDR_W + 1;
    localparam int DATA_BITS = CODE_W + 1;
    localparam int SH_W      = (ADDR_BITS > DATA_BITS) ? ADDR_BITS : DATA_BITS;
    localparam int CNT_W     = $clog2(SH_W + 1);

    logic scl_f, sda_f;
    logic start_ev, stop_ev, rise_ev, fall_ev;

    slv_state_t        state;
    logic [CNT_W-1:0]  bit_cnt;
    logic [SH_W-1:0]   rx_sh;
    logic [CODE_W-1:0] tx_sh;
    logic              rw_q, ack_q, cmd_ack;

    // One filter per bus line
    for (genvar g = 0; g < 2; g++) begin : g_filt
        if (g == 0) begin : g_scl
            i2c_line_filter #(.FILT_CYC(FILT_CYC)) u_f (
                .clk(clk), .rst_n(rst_n), .raw_i(scl_i), .clean_o(scl_f));
        end else begin : g_sda
            i2c_line_filter #(.FILT_CYC(FILT_CYC)) u_f (
                .clk(clk), .rst_n(rst_n), .raw_i(sda_i), .clean_o(sda_f));
        end
    end

    i2c_bus_events u_ev (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_f), .sda_i(sda_f),
        .start_o(start_ev), .stop_o(stop_ev),
        .rise_o(rise_ev), .fall_o(fall_ev)
    );

    // A DAC write is always acknowledged; a store only if the bank accepts it
    assign cmd_ack = rx_sh[0] | store_ready_i;

    // Protocol sequencer: bit counting, ACK driving, register update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= ST_IDLE;
            bit_cnt      <= '0;
            rx_sh        <= '0;
            tx_sh        <= '0;
            rw_q         <= 1'b0;
            ack_q        <= 1'b0;
            sda_oe_o     <= 1'b0;
            store_req_o  <= 1'b0;
            store_code_o <= '0;
            dac_code_o   <= RESET_CODE;
        end else begin
            store_req_o <= 1'b0;
            if (start_ev) begin
                state    <= ST_ADDR;
                bit_cnt  <= '0;
                sda_oe_o <= 1'b0;
            end else if (stop_ev) begin
                state    <= ST_IDLE;
                sda_oe_o <= 1'b0;
            end else begin
                unique case (state)
                    ST_ADDR: begin
                        if (rise_ev) begin
                            rx_sh   <= {rx_sh[SH_W-2:0], sda_f};
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (fall_ev && bit_cnt == CNT_W'(ADDR_BITS)) begin
                            if (rx_sh[ADDR_W:1] == DEV_ADDR) begin
                                sda_oe_o <= 1'b1;
                                rw_q     <= rx_sh[0];
                                state    <= ST_AACK;
                            end else begin
                                state <= ST_IGN;
                            end
                        end
                    end
                    ST_AACK: begin
                        if (fall_ev) begin
                            bit_cnt <= '0;
                            if (rw_q) begin
                                tx_sh    <= {dac_code_o[CODE_W-2:0], 1'b0};
                                sda_oe_o <= ~dac_code_o[CODE_W-1];
                                state    <= ST_RDAT;
                            end else begin
                                sda_oe_o <= 1'b0;
                                state    <= ST_WDAT;
                            end
                        end
                    end
                    ST_WDAT: begin
                        if (rise_ev) begin
                            rx_sh   <= {rx_sh[SH_W-2:0], sda_f};
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (fall_ev && bit_cnt == CNT_W'(DATA_BITS)) begin
                            sda_oe_o <= cmd_ack;
                            ack_q    <= cmd_ack;
                            state    <= ST_WACK;
                        end
                    end
                    ST_WACK: begin
                        if (fall_ev) begin
                            sda_oe_o <= 1'b0;
                            state    <= ST_IGN;
                            if (ack_q) begin
                                if (rx_sh[0]) begin
                                    dac_code_o <= rx_sh[CODE_W:1];
                                end else begin
                                    store_req_o  <= 1'b1;
                                    store_code_o <= rx_sh[CODE_W:1];
                                end
                            end
                        end
                    end
                    ST_RDAT: begin
                        if (rise_ev) begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (fall_ev) begin
                            if (bit_cnt == CNT_W'(DATA_BITS)) begin
                                sda_oe_o <= 1'b0;
                                state    <= ST_RACK;
                            end else begin
                                sda_oe_o <= ~tx_sh[CODE_W-1];
                                tx_sh    <= {tx_sh[CODE_W-2:0], 1'b0};
                            end
                        end
                    end
                    ST_RACK: begin
                        if (fall_ev) state <= ST_IGN;
                    end
                    default: ;
                endcase
            end
        end
    end

    // R1
    oe_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE || state == ST_IGN) |-> !sda_oe_o);
    // R2
    dac_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_code_o != $past(dac_code_o)) |-> ($past(state) == ST_WACK && $past(ack_q)));
    // R3
    store_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        store_req_o |=> !store_req_o);
    // R4
    store_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        store_req_o |-> ($past(state) == ST_WACK && $past(ack_q)));
    // R10
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_ev |=> (state == ST_ADDR));
    // R7
    stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> (state == ST_IDLE));
endmodule

// File: tb/tb_vcom_i2c_slave.sv
module tb_vcom_i2c_slave;
    localparam int CLK_PERIOD = 10;
    localparam int H          = 24;
    localparam logic [6:0] ADDR = 7'h4F;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1, m_sda = 1'b1;
    logic       store_ready = 1'b0;
    logic       sda_oe, store_req;
    logic [6:0] store_code, dac_code;
    logic       sda_bus;

    int checks = 0, fails = 0;
    int store_cnt = 0;
    logic [6:0] last_store = '0;
    logic [6:0] exp_dac = 7'd64;
    bit done = 0;

    assign sda_bus = m_sda & ~sda_oe;
    always #(CLK_PERIOD/2) clk = ~clk;

    vcom_i2c_slave dut (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
        .sda_oe_o(sda_oe), .store_ready_i(store_ready), .store_req_o(store_req),
        .store_code_o(store_code), .dac_code_o(dac_code)
    );

    // Counts store pulses away from the active edge
    always @(negedge clk) begin
        if (rst_n && store_req) begin
            store_cnt++;
            last_store = store_code;
        end
    end

    function automatic bit exp_data_ack(input logic [7:0] b, input bit ready);
        return b[0] | ready;
    endfunction
    function automatic logic [7:0] exp_read(input logic [6:0] code);
        return {code, 1'b0};
    endfunction
    function automatic bit addr_hit(input logic [7:0] a);
        return a[7:1] == ADDR;
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start;
        m_sda = 1; wt(H/2); m_scl = 1; wt(H);
        m_sda = 0; wt(H);
        m_scl = 0; wt(H/2);
    endtask

    task automatic bus_stop;
        m_sda = 0; wt(H/2); m_scl = 1; wt(H);
        m_sda = 1; wt(2*H);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit glitch, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; wt(H/2);
            m_scl = 1;
            if (glitch && i == 4) begin
                wt(H/2); m_scl = 0; wt(3); m_scl = 1; wt(H/2 - 3);
            end else if (glitch && i == 2 && b[i]) begin
                wt(H/2); m_sda = 0; wt(3); m_sda = 1; wt(H/2 - 3);
            end else begin
                wt(H);
            end
            m_scl = 0; wt(H/2);
        end
        m_sda = 1; wt(H/2);
        m_scl = 1; wt(H/2);
        ack = !sda_bus;
        wt(H/2); m_scl = 0; wt(H/2);
    endtask

    task automatic recv_byte(output logic [7:0] b);
        m_sda = 1;
        for (int i = 7; i >= 0; i--) begin
            wt(H/2); m_scl = 1; wt(H/2);
            b[i] = sda_bus;
            wt(H/2); m_scl = 0; wt(H/2);
        end
        wt(H/2); m_scl = 1; wt(H); m_scl = 0; wt(H/2);
    endtask

    task automatic do_write(input logic [7:0] a, input logic [7:0] d, input bit ready,
                            input bit glitch, output bit aa, output bit da);
        store_ready = ready;
        bus_start;
        send_byte(a, 1'b0, aa);
        send_byte(d, glitch, da);
        bus_stop;
    endtask

    task automatic do_read(output bit aa, output logic [7:0] b);
        bus_start;
        send_byte(8'h9F, 1'b0, aa);
        recv_byte(b);
        bus_stop;
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        bit aa, da;
        logic [7:0] rb;
        int sc;

        wt(10);
        // R6 reset state
        check("R6", "dac after reset", dac_code, 64);
        check("R6", "sda_oe after reset", sda_oe, 0);
        check("R6", "store_req after reset", store_req, 0);
        rst_n = 1; wt(20);

        // R2 direct DAC write
        do_write(8'h9E, {7'h2A, 1'b1}, 0, 0, aa, da);
        check("R1", "addr ack 0x9E", aa, 1);
        check("R2", "data ack", da, 1);
        check("R2", "dac value", dac_code, 7'h2A);
        exp_dac = 7'h2A;

        // R5 read back
        do_read(aa, rb);
        check("R5", "read addr ack", aa, 1);
        check("R5", "read byte", rb, exp_read(exp_dac));

        // R3 accepted store
        sc = store_cnt;
        do_write(8'h9E, {7'h11, 1'b0}, 1, 0, aa, da);
        check("R3", "store ack", da, 1);
        check("R3", "store pulse count", store_cnt, sc + 1);
        check("R3", "store code", last_store, 7'h11);
        check("R3", "dac unchanged by store", dac_code, exp_dac);

        // R4 refused store
        sc = store_cnt;
        do_write(8'h9E, {7'h22, 1'b0}, 0, 0, aa, da);
        check("R4", "refused store nack", da, 0);
        check("R4", "no store pulse", store_cnt, sc);
        check("R4", "dac unchanged", dac_code, exp_dac);

        // R1 foreign address ignored
        do_write(8'hA0, {7'h7F, 1'b1}, 0, 0, aa, da);
        check("R1", "foreign addr nack", aa, 0);
        check("R1", "data ignored nack", da, 0);
        check("R1", "dac unchanged", dac_code, exp_dac);

        // R7 STOP in the middle of the data byte
        bus_start;
        send_byte(8'h9E, 1'b0, aa);
        for (int i = 0; i < 4; i++) begin
            m_sda = 1; wt(H/2); m_scl = 1; wt(H); m_scl = 0; wt(H/2);
        end
        bus_stop;
        check("R7", "dac after aborted write", dac_code, exp_dac);

        // R8 STOP in the START's own SCL high phase is ignored
        m_sda = 1; m_scl = 1; wt(H);
        m_sda = 0; wt(H/2);
        m_sda = 1; wt(H/2);
        m_scl = 0; wt(H/2);
        send_byte(8'h9E, 1'b0, aa);
        send_byte({7'h33, 1'b1}, 1'b0, da);
        bus_stop;
        check("R8", "addr ack after masked stop", aa, 1);
        check("R8", "dac after masked stop", dac_code, 7'h33);
        exp_dac = 7'h33;

        // R10 repeated START after a foreign address
        bus_start;
        send_byte(8'hA2, 1'b0, aa);
        bus_start;
        send_byte(8'h9E, 1'b0, aa);
        send_byte({7'h05, 1'b1}, 1'b0, da);
        bus_stop;
        check("R10", "ack after repeated start", aa, 1);
        check("R10", "dac after repeated start", dac_code, 7'h05);
        exp_dac = 7'h05;

        // R9 short spikes on SCL and SDA
        do_write(8'h9E, {7'h36, 1'b1}, 0, 1, aa, da);
        check("R9", "ack with spikes", da, 1);
        check("R9", "dac with spikes", dac_code, 7'h36);
        exp_dac = 7'h36;

        // Random traffic
        void'($urandom(32'd20240611));
        for (int n = 0; n < 50; n++) begin
            int kind = $urandom_range(0, 3);
            logic [6:0] code = 7'($urandom_range(0, 127));
            bit ready = 1'($urandom_range(0, 1));
            case (kind)
                0: begin
                    do_write(8'h9E, {code, 1'b1}, ready, 0, aa, da);
                    exp_dac = code;
                    check("R2", "rand dac ack", da, 1);
                    check("R2", "rand dac value", dac_code, exp_dac);
                end
                1: begin
                    sc = store_cnt;
                    do_write(8'h9E, {code, 1'b0}, ready, 0, aa, da);
                    check(ready ? "R3" : "R4", "rand store ack", da,
                          exp_data_ack({code, 1'b0}, ready));
                    check(ready ? "R3" : "R4", "rand store count", store_cnt, sc + int'(ready));
                    if (ready) check("R3", "rand store code", last_store, code);
                    check("R4", "rand dac kept", dac_code, exp_dac);
                end
                2: begin
                    do_read(aa, rb);
                    check("R5", "rand read", rb, exp_read(exp_dac));
                end
                default: begin
                    logic [7:0] a = 8'($urandom_range(0, 255));
                    if (addr_hit(a)) a = 8'h10;
                    do_write(a, {code, 1'b1}, ready, 0, aa, da);
                    check("R1", "rand foreign ack", aa, 0);
                    check("R1", "rand foreign dac", dac_code, exp_dac);
                end
            endcase
        end
        done = 1;
        finish_run;
    end

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            finish_run;
        end
    end
endmodule